// File: doc/BRIEF.md
# Quadrature Position Counter with Masked Index Clear

The block keeps a 16-bit signed-free position count that moves one step at a time under the control of two phase inputs, two trigger inputs and two external event strobes. Every input is sampled in the core clock domain and turned into level, rising-edge and falling-edge information. Two independent five-bit selectors, each with its own enable, pick the condition that steps the count up and the condition that steps it down. The phase conditions are qualified by the level of the opposite phase. This lets a quadrature encoder be decoded at one, two or four counts per cycle, depending on which codes are chosen.

An index input clears the count to zero on its rising edge. After every overflow or underflow, the index can be masked for 4, 8 or 16 counting steps. This stops the index from clearing the count near the wrap point. A separate enable lets the index clear the count even while the mask is running. The outputs are the count, a direction flag and single-cycle overflow and underflow strobes.

Top module: `quad_pos_counter`

## Requirements
- R1: During and right after a synchronous reset, count is 0, dir_up is 1, and ovf and udf are 0.
- R2: Selector codes 0 to 7 mean, in this order: B rise while A low, B fall while A low, B rise while A high, B fall while A high, A rise while B low, A fall while B low, A rise while B high, A fall while B high. A phase edge that does not match the selected code leaves the count unchanged.
- R3: Code 8 is trig_a rising, 9 is trig_a falling, 10 is trig_b rising, 11 is trig_b falling, 16 is evt0 rising and 17 is evt1 rising. Every other code never matches.
- R4: up_en and dn_en gate their selectors independently. A disabled direction never moves the count.
- R5: If the up and down conditions both match in the same cycle, the count and dir_up both hold.
- R6: An up step from 0xFFFF gives 0 and a one-cycle ovf pulse.
- R7: A down step from 0 loads the period input and gives a one-cycle udf pulse.
- R8: dir_up becomes 1 on every applied up step and 0 on every applied down step.
- R9: A rising edge on index_z clears the count to 0 when no mask is running. The clear takes priority over a count step in the same cycle.
- R10: zmask_sel value 0 means no mask. Values 1, 2 and 3 mask the index for 4, 8 and 16 applied count steps after a wrap. While the mask runs, the index clears the count only if zclr_in_mask is 1.
- R11: Every new overflow or underflow reloads the full mask length, even if a mask is already running.
- R12: A count step shows on count at the second rising clock edge after the input change, not at the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_a | input | 1 | Phase A input |
| phase_b | input | 1 | Phase B input |
| trig_a | input | 1 | Trigger input A |
| trig_b | input | 1 | Trigger input B |
| evt0 | input | 1 | External event strobe 0 |
| evt1 | input | 1 | External event strobe 1 |
| index_z | input | 1 | Index input; its rising edge clears the count |
| up_sel | input | 5 | Up-count condition code |
| up_en | input | 1 | Enable for the up-count condition |
| dn_sel | input | 5 | Down-count condition code |
| dn_en | input | 1 | Enable for the down-count condition |
| period | input | 16 | Value loaded on underflow |
| zmask_sel | input | 2 | Index mask length select |
| zclr_in_mask | input | 1 | Lets the index clear the count while the mask runs |
| count | output | 16 | Position count |
| dir_up | output | 1 | Direction of the last applied step, 1 for up |
| ovf | output | 1 | One-cycle overflow strobe |
| udf | output | 1 | One-cycle underflow strobe |

## Verification
The phase tests pair an A-rise selected for up with an A-rise-while-B-high selected for down. A correct count then shows that the opposite-phase level is decoded, and that unselected edges such as B rising or A falling do nothing. Trigger and event edges are tried alone and against a code that never matches, to tell edge polarity apart from a stuck decode. Wraps in both directions are reached by using a period of 0xFFFF, so the up wrap is exercised without a long count. Index edges are placed just before and just after the end of a mask window, and after a second wrap, to tell a mask that expires on time from one that was never reloaded.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  // Bit positions of the sampled input vector
  localparam int IX_A   = 0;
  localparam int IX_B   = 1;
  localparam int IX_TA  = 2;
  localparam int IX_TB  = 3;
  localparam int IX_E0  = 4;
  localparam int IX_E1  = 5;
  localparam int IX_Z   = 6;
  localparam int NUM_IN = 7;

  localparam int SEL_W  = 5;
  localparam int MASK_W = 5;

  typedef logic [SEL_W-1:0] sel_t;

  // Mask length in count steps for a mask select value: 0, 4, 8 or 16
  function automatic logic [MASK_W-1:0] mask_len(input logic [1:0] s);
    if (s == 2'd0) return '0;
    return MASK_W'(2) << s;
  endfunction
endpackage

// File: rtl/qpc_edge.sv
module qpc_edge #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] smp_q, hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= '0;
      hist_q <= '0;
    end else begin
      smp_q  <= raw;
      hist_q <= smp_q;
    end
  end

  assign lvl  = smp_q;
  assign rise = smp_q & ~hist_q;
  assign fall = ~smp_q & hist_q;
endmodule

// File: rtl/qpc_cond_sel.sv
module qpc_cond_sel
  import qpc_pkg::*;
(
  input  logic [NUM_IN-1:0] lvl,
  input  logic [NUM_IN-1:0] rise,
  input  logic [NUM_IN-1:0] fall,
  input  sel_t              sel,
  input  logic              en,
  output logic              hit
);
  logic match;

  always_comb begin
    unique case (sel)
      5'd0:    match = rise[IX_B] & ~lvl[IX_A];
      5'd1:    match = fall[IX_B] & ~lvl[IX_A];
      5'd2:    match = rise[IX_B] &  lvl[IX_A];
      5'd3:    match = fall[IX_B] &  lvl[IX_A];
      5'd4:    match = rise[IX_A] & ~lvl[IX_B];
      5'd5:    match = fall[IX_A] & ~lvl[IX_B];
      5'd6:    match = rise[IX_A] &  lvl[IX_B];
      5'd7:    match = fall[IX_A] &  lvl[IX_B];
      5'd8:    match = rise[IX_TA];
      5'd9:    match = fall[IX_TA];
      5'd10:   match = rise[IX_TB];
      5'd11:   match = fall[IX_TB];
      5'd16:   match = rise[IX_E0];
      5'd17:   match = rise[IX_E1];
      default: match = 1'b0;
    endcase
  end

  assign hit = en & match;
endmodule

// File: rtl/qpc_zmask.sv
module qpc_zmask
  import qpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap,
  input  logic              step,
  input  logic [1:0]        zsel,
  output logic [MASK_W-1:0] left,
  output logic              active
);
  logic [MASK_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (wrap) begin
      left_q <= mask_len(zsel);
    end else if (step && left_q != '0) begin
      left_q <= left_q - MASK_W'(1);
    end
  end

  assign left   = left_q;
  assign active = (left_q != '0);
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             trig_a,
  input  logic             trig_b,
  input  logic             evt0,
  input  logic             evt1,
  input  logic             index_z,
  input  logic [4:0]       up_sel,
  input  logic             up_en,
  input  logic [4:0]       dn_sel,
  input  logic             dn_en,
  input  logic [CNT_W-1:0] period,
  input  logic [1:0]       zmask_sel,
  input  logic             zclr_in_mask,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic             ovf,
  output logic             udf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [NUM_IN-1:0] raw_in, lvl, rise, fall;
  logic              hit_up, hit_dn, mask_on, zclr;
  logic              move_up, move_dn, wrap;
  logic [MASK_W-1:0] mask_left;

  logic [CNT_W-1:0] count_q;
  logic             dir_q, ovf_q, udf_q;

  assign raw_in = {index_z, evt1, evt0, trig_b, trig_a, phase_b, phase_a};

  qpc_edge #(.N(NUM_IN)) u_edge (
    .clk (clk), .rst (rst), .raw (raw_in),
    .lvl (lvl), .rise (rise), .fall (fall)
  );

  qpc_cond_sel u_up_sel (
    .lvl (lvl), .rise (rise), .fall (fall),
    .sel (up_sel), .en (up_en), .hit (hit_up)
  );

  qpc_cond_sel u_dn_sel (
    .lvl (lvl), .rise (rise), .fall (fall),
    .sel (dn_sel), .en (dn_en), .hit (hit_dn)
  );

  // Index clear wins over any count step in the same cycle (R9)
  assign zclr    = rise[IX_Z] & (~mask_on | zclr_in_mask);
  assign move_up = hit_up & ~hit_dn & ~zclr;
  assign move_dn = hit_dn & ~hit_up & ~zclr;
  assign wrap    = (move_up && count_q == CNT_MAX) || (move_dn && count_q == '0);

  qpc_zmask u_zmask (
    .clk (clk), .rst (rst), .wrap (wrap),
    .step (move_up | move_dn), .zsel (zmask_sel),
    .left (mask_left), .active (mask_on)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      dir_q   <= 1'b1;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
      if (zclr) begin
        count_q <= '0;
      end else if (move_up) begin
        dir_q <= 1'b1;
        if (count_q == CNT_MAX) begin
          count_q <= '0;
          ovf_q   <= 1'b1;
        end else begin
          count_q <= count_q + CNT_ONE;
        end
      end else if (move_dn) begin
        dir_q <= 1'b0;
        if (count_q == '0) begin
          count_q <= period;
          udf_q   <= 1'b1;
        end else begin
          count_q <= count_q - CNT_ONE;
        end
      end
    end
  end

  assign count  = count_q;
  assign dir_up = dir_q;
  assign ovf    = ovf_q;
  assign udf    = udf_q;
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker
  import qpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  count,
  input logic              dir_up,
  input logic              ovf,
  input logic              udf,
  input logic [CNT_W-1:0]  period,
  input logic [1:0]        zmask_sel,
  input logic [MASK_W-1:0] mask_left
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R1: state right after a reset cycle
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (count == '0 && dir_up && !ovf && !udf));

  // R6: overflow lands on zero while counting up
  p_ovf_zero_r6: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (count == '0 && dir_up));

  // R6, R7: never both strobes at once
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(ovf && udf));

  // R7: underflow loads the period seen on the wrap edge
  p_udf_period_r7: assert property (@(posedge clk) disable iff (rst)
    udf |-> (count == $past(period) && !dir_up));

  // R5, R9: count moves by one, clears, or wraps
  p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |->
      (count == $past(count) + ONE || count == $past(count) - ONE ||
       count == '0 || udf));

  // R8: direction only changes together with an applied step
  p_dir_with_step_r8: assert property (@(posedge clk) disable iff (rst)
    (dir_up != $past(dir_up)) |-> (count != $past(count) || udf));

  // R10, R11: every wrap loads the full mask length
  p_mask_reload_r11: assert property (@(posedge clk) disable iff (rst)
    (ovf || udf) |-> (mask_left == mask_len($past(zmask_sel))));
endmodule

bind quad_pos_counter qpc_checker #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .count     (count),
  .dir_up    (dir_up),
  .ovf       (ovf),
  .udf       (udf),
  .period    (period),
  .zmask_sel (zmask_sel),
  .mask_left (mask_left)
);

// File: tb/quad_pos_counter_tb_top.sv
`timescale 1ns/1ps
module quad_pos_counter_tb_top;
  localparam int IA = 0, IB = 1, ITA = 2, ITB = 3, IE0 = 4, IE1 = 5, IZ = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  ins = '0;
  logic [4:0]  up_sel = 5'd4, dn_sel = 5'd6;
  logic        up_en = 1'b1, dn_en = 1'b1;
  logic [15:0] period = 16'h0010;
  logic [1:0]  zmask_sel = 2'd0;
  logic        zclr_in_mask = 1'b0;
  logic [15:0] count;
  logic        dir_up, ovf, udf;

  typedef struct {
    logic [15:0] c;
    logic        d, o, u;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t mon_e;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  quad_pos_counter dut_i (
    .clk (clk), .rst (rst),
    .phase_a (ins[IA]), .phase_b (ins[IB]),
    .trig_a (ins[ITA]), .trig_b (ins[ITB]),
    .evt0 (ins[IE0]), .evt1 (ins[IE1]), .index_z (ins[IZ]),
    .up_sel (up_sel), .up_en (up_en), .dn_sel (dn_sel), .dn_en (dn_en),
    .period (period), .zmask_sel (zmask_sel), .zclr_in_mask (zclr_in_mask),
    .count (count), .dir_up (dir_up), .ovf (ovf), .udf (udf)
  );

  // Monitor: compares one expected item per falling edge
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      mon_e = sb_q.pop_front();
      n_chk++;
      if (count !== mon_e.c || dir_up !== mon_e.d || ovf !== mon_e.o || udf !== mon_e.u) begin
        n_fail++;
        $display("FAIL %s: got cnt=%h dir=%b ovf=%b udf=%b, expected cnt=%h dir=%b ovf=%b udf=%b",
                 mon_e.tag, count, dir_up, ovf, udf, mon_e.c, mon_e.d, mon_e.o, mon_e.u);
      end
    end
  end

  task automatic push_exp(input logic [15:0] c, input logic d, o, u, input string tag);
    exp_t e;
    e.c = c; e.d = d; e.o = o; e.u = u; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Driver: change one input at a falling edge, expect result after two rising edges
  task automatic poke(input int idx, input logic v, input logic [15:0] c,
                      input logic d, o, u, input string tag);
    ins[idx] = v;
    @(posedge clk); @(posedge clk); #1;
    push_exp(c, d, o, u, tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    push_exp(16'h0000, 1'b1, 1'b0, 1'b0, "R1 reset state");
    @(negedge clk);

    // R12: nothing after one edge, the step after the second
    ins[IA] = 1'b1;
    @(posedge clk); #1;
    push_exp(16'h0000, 1'b1, 1'b0, 1'b0, "R12 no change after first edge");
    @(posedge clk); #1;
    push_exp(16'h0001, 1'b1, 1'b0, 1'b0, "R2 A rise with B low counts up");
    @(negedge clk);

    poke(IA, 1'b0, 16'h0001, 1'b1, 1'b0, 1'b0, "R2 A fall unselected");
    poke(IB, 1'b1, 16'h0001, 1'b1, 1'b0, 1'b0, "R2 B rise unselected");
    poke(IA, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, "R8 A rise with B high counts down");
    poke(IA, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, "R2 hold");
    poke(IA, 1'b1, 16'h0010, 1'b0, 1'b0, 1'b1, "R7 down wrap loads period");
    poke(IA, 1'b0, 16'h0010, 1'b0, 1'b0, 1'b0, "R7 udf is one cycle");
    poke(IZ, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, "R9 index clears");
    poke(IZ, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, "R9 index fall no effect");
    poke(IB, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, "R2 B fall unselected");

    dn_sel = 5'd4;
    poke(IA, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, "R5 both conditions hold");
    poke(IA, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, "R5 hold");

    up_sel = 5'd8; dn_sel = 5'd11;
    poke(ITA, 1'b1, 16'h0001, 1'b1, 1'b0, 1'b0, "R3 trig_a rise up");
    poke(ITB, 1'b1, 16'h0001, 1'b1, 1'b0, 1'b0, "R3 trig_b rise not selected");
    poke(ITB, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, "R3 trig_b fall down");
    poke(ITA, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, "R3 trig_a fall not selected");

    up_sel = 5'd16; dn_sel = 5'd17;
    poke(IE0, 1'b1, 16'h0001, 1'b1, 1'b0, 1'b0, "R3 evt0 up");
    poke(IE0, 1'b0, 16'h0001, 1'b1, 1'b0, 1'b0, "R3 evt0 fall no effect");
    poke(IE1, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, "R3 evt1 down");
    poke(IE1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, "R3 evt1 fall no effect");

    up_sel = 5'd12; dn_sel = 5'd15;
    poke(ITA, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, "R3 unused code never matches");
    poke(ITA, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, "R3 unused code never matches");

    up_sel = 5'd8; up_en = 1'b0; dn_sel = 5'd9;
    poke(ITA, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, "R4 disabled up ignored");
    poke(ITA, 1'b0, 16'h0010, 1'b0, 1'b0, 1'b1, "R4 enabled down still works");
    poke(IZ, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, "R9 index clears");
    poke(IZ, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, "R9 hold");

    period = 16'hFFFF; up_en = 1'b1; up_sel = 5'd8; dn_sel = 5'd10;
    poke(ITB, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b1, "R7 wrap to period FFFF");
    poke(ITB, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R7 hold");
    zmask_sel = 2'd1;
    poke(ITA, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0, "R6 up wrap with ovf");
    poke(ITA, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, "R6 ovf is one cycle");
    poke(ITA, 1'b1, 16'h0001, 1'b1, 1'b0, 1'b0, "R10 step 1 in mask");
    poke(IZ,  1'b1, 16'h0001, 1'b1, 1'b0, 1'b0, "R10 index masked");
    poke(IZ,  1'b0, 16'h0001, 1'b1, 1'b0, 1'b0, "R10 hold");
    poke(ITA, 1'b0, 16'h0001, 1'b1, 1'b0, 1'b0, "R10 hold");
    poke(ITA, 1'b1, 16'h0002, 1'b1, 1'b0, 1'b0, "R10 step 2");
    poke(ITA, 1'b0, 16'h0002, 1'b1, 1'b0, 1'b0, "R10 hold");
    poke(ITA, 1'b1, 16'h0003, 1'b1, 1'b0, 1'b0, "R10 step 3");
    poke(IZ,  1'b1, 16'h0003, 1'b1, 1'b0, 1'b0, "R10 index masked at last step");
    poke(IZ,  1'b0, 16'h0003, 1'b1, 1'b0, 1'b0, "R10 hold");
    poke(ITA, 1'b0, 16'h0003, 1'b1, 1'b0, 1'b0, "R10 hold");
    poke(ITA, 1'b1, 16'h0004, 1'b1, 1'b0, 1'b0, "R10 step 4 ends mask");
    poke(IZ,  1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, "R10 index clears after mask");
    poke(IZ,  1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, "R10 hold");

    zclr_in_mask = 1'b1;
    poke(ITB, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b1, "R10 wrap starts mask");
    poke(IZ,  1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, "R10 index allowed in mask");
    poke(IZ,  1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, "R10 hold");

    zclr_in_mask = 1'b0;
    poke(ITA, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, "R11 hold");
    poke(ITB, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, "R11 hold");
    poke(ITB, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b1, "R11 first wrap");
    poke(ITA, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0, "R11 second wrap");
    poke(ITA, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, "R11 hold");
    poke(ITA, 1'b1, 16'h0001, 1'b1, 1'b0, 1'b0, "R11 step");
    poke(ITA, 1'b0, 16'h0001, 1'b1, 1'b0, 1'b0, "R11 hold");
    poke(ITA, 1'b1, 16'h0002, 1'b1, 1'b0, 1'b0, "R11 step");
    poke(ITA, 1'b0, 16'h0002, 1'b1, 1'b0, 1'b0, "R11 hold");
    poke(ITA, 1'b1, 16'h0003, 1'b1, 1'b0, 1'b0, "R11 step");
    poke(IZ,  1'b1, 16'h0003, 1'b1, 1'b0, 1'b0, "R11 reloaded mask still blocks index");
    poke(IZ,  1'b0, 16'h0003, 1'b1, 1'b0, 1'b0, "R11 hold");

    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no end of stimulus, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule